// File: doc/BRIEF.md
# Vectored Fixed-Priority Interrupt Arbiter

This block sits beside a small microcontroller core and decides which interrupt the core services next. It watches one reset request and a parameterised set of peripheral request lines (seventeen by default). Each peripheral line has a private enable bit. A global enable bit, held here on behalf of the core's status register, gates all of them. A rising edge on a request line latches a pending flag. The highest-priority pending and enabled source is then offered to the core as a one-cycle strobe, together with the program-memory word address of its vector.

Vector slots sit at the bottom of program memory, two words apart, with reset in slot 0. Peripheral line k owns slot k+1. The slot number is also the priority: a lower slot wins. Taking an interrupt clears the global enable. A return-from-interrupt pulse from the core sets it again. The core acknowledges the taken source with a pulse, and that pulse clears the source's pending flag. The status register is neither saved nor restored here; software does that.

Top module: `irq_vector_arbiter`

## Requirements
- R1: A high `rst_req` sampled at a clock edge makes `irq_req` high after that edge with `irq_vec` equal to 0, whatever the enable bits are. At the same edge it clears `gie` and every bit of `en`.
- R2: A 0-to-1 change on `irq_lines[k]` latches a pending flag. The flag holds while the source is masked, and the source is taken once it becomes unmasked.
- R3: Line k is taken only when its pending flag, `en[k]` and `gie` are all 1. With all three set, the strobe rises after the second clock edge that follows the line's rise.
- R4: When several sources are pending and enabled, the lowest line index wins.
- R5: The vector address for line k is 2·(k+1), and reset's vector address is 0.
- R6: `irq_req` is high for exactly one cycle per taken source. `gie` reads 0 in that same cycle, and nothing else is taken until `gie` is set again.
- R7: A `reti` pulse sets `gie`. When `gie_wr` is high at the same edge, the written value wins.
- R8: An `irq_ack` pulse clears only the pending flag of the most recently taken source. Other pending sources are then taken later in priority order.
- R9: `en_wr` loads `en_wdata` into `en`, and `gie_wr` loads `gie_wdata` into `gie`. Both registers read back on their outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low register reset |
| rst_req | input | 1 | Reset interrupt request, highest priority |
| irq_lines | input | NUM_SRC | Peripheral request lines, edge-latched |
| en_wr | input | 1 | Write strobe for the per-source enables |
| en_wdata | input | NUM_SRC | Enable value to write |
| en | output | NUM_SRC | Per-source enable bits |
| gie_wr | input | 1 | Write strobe for the global enable |
| gie_wdata | input | 1 | Global enable value to write |
| gie | output | 1 | Global interrupt enable |
| reti | input | 1 | Return-from-interrupt pulse, sets the global enable |
| irq_ack | input | 1 | Core acknowledge of the taken source |
| irq_req | output | 1 | One-cycle interrupt strobe to the core |
| irq_vec | output | ADDR_W | Vector word address, valid while irq_req is high |

## Verification
Some internal faults are visible at once. A pending flag that is lost, or one that never clears, shows up on the ports as either a missing strobe or a second strobe for the same source. That second strobe appears one cycle after the next `reti`. A fault in the priority encoder or the vector generator gives a wrong `irq_vec` in the very cycle the strobe rises. The global enable is the one internal state that is also an output. A mistake in its set/clear precedence therefore shows on `gie` one edge after the conflicting inputs, and it can also show as a strobe that should not have been issued.

// File: rtl/irqv_pkg.sv
package irqv_pkg;

   typedef enum logic [0:0] {
      PRIO_SCAN    = 1'b0,
      PRIO_ISOLATE = 1'b1
   } prio_impl_e;

   function automatic int slot_addr(input int base, input int stride, input int slot);
      return base + slot * stride;
   endfunction

endpackage

// File: rtl/irqv_pending.sv
module irqv_pending #(
   parameter int N = 17
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] lines,
   input  logic [N-1:0] clr,
   output logic [N-1:0] pend
);

   logic [N-1:0] lines_q;
   logic [N-1:0] rise;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lines_q <= '0;
      else        lines_q <= lines;
   end

   assign rise = lines & ~lines_q;

   for (genvar i = 0; i < N; i++) begin : g_flag
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)       pend[i] <= 1'b0;
         else if (rise[i]) pend[i] <= 1'b1;
         else if (clr[i])  pend[i] <= 1'b0;
      end
   end

endmodule

// File: rtl/irqv_prio.sv
module irqv_prio
   import irqv_pkg::*;
#(
   parameter int         N    = 17,
   parameter int         IW   = 5,
   parameter prio_impl_e IMPL = PRIO_SCAN
) (
   input  logic [N-1:0]  req,
   output logic          valid,
   output logic [IW-1:0] idx
);

   if (2 ** IW < N) begin : g_bad_iw
      $error("irqv_prio: IW too narrow for N");
   end

   assign valid = |req;

   if (IMPL == PRIO_SCAN) begin : g_scan
      always_comb begin
         idx = '0;
         for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IW'(i);
         end
      end
   end else begin : g_isolate
      logic [N-1:0] lowest;
      assign lowest = req & (~req + N'(1));
      always_comb begin
         idx = '0;
         for (int i = 0; i < N; i++) begin
            if (lowest[i]) idx = idx | IW'(i);
         end
      end
   end

endmodule

// File: rtl/irqv_vecgen.sv
module irqv_vecgen
   import irqv_pkg::*;
#(
   parameter int IW     = 5,
   parameter int AW     = 13,
   parameter int BASE   = 0,
   parameter int STRIDE = 2
) (
   input  logic [IW-1:0] slot,
   output logic [AW-1:0] addr
);

   if ((STRIDE & (STRIDE - 1)) == 0) begin : g_shift
      localparam int SH = $clog2(STRIDE);
      assign addr = AW'(BASE) + (AW'(slot) << SH);
   end else begin : g_mult
      assign addr = AW'(slot_addr(BASE, STRIDE, int'(slot)));
   end

endmodule

// File: rtl/irq_vector_arbiter.sv
module irq_vector_arbiter
   import irqv_pkg::*;
#(
   parameter int         NUM_SRC    = 17,
   parameter int         ADDR_W     = 13,
   parameter int         VEC_BASE   = 0,
   parameter int         VEC_STRIDE = 2,
   parameter prio_impl_e PRIO_IMPL  = PRIO_SCAN
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               rst_req,
   input  logic [NUM_SRC-1:0] irq_lines,
   input  logic               en_wr,
   input  logic [NUM_SRC-1:0] en_wdata,
   output logic [NUM_SRC-1:0] en,
   input  logic               gie_wr,
   input  logic               gie_wdata,
   output logic               gie,
   input  logic               reti,
   input  logic               irq_ack,
   output logic               irq_req,
   output logic [ADDR_W-1:0]  irq_vec
);

   localparam int IDX_W    = $clog2(NUM_SRC + 1);
   localparam int LAST_VEC = VEC_BASE + NUM_SRC * VEC_STRIDE;

   if (NUM_SRC < 1) begin : g_bad_n
      $error("irq_vector_arbiter: NUM_SRC must be at least 1");
   end
   if (VEC_STRIDE < 1) begin : g_bad_stride
      $error("irq_vector_arbiter: VEC_STRIDE must be at least 1");
   end
   if (LAST_VEC >= 2 ** ADDR_W) begin : g_bad_aw
      $error("irq_vector_arbiter: ADDR_W cannot hold the last vector");
   end

   logic [NUM_SRC-1:0] pend;
   logic [NUM_SRC-1:0] taken_q;
   logic [NUM_SRC-1:0] ack_clr;
   logic [NUM_SRC-1:0] live;
   logic               win_valid;
   logic [IDX_W-1:0]   win_idx;
   logic               take;
   logic [IDX_W-1:0]   slot_q;
   logic               req_q;
   logic               gie_q;
   logic [NUM_SRC-1:0] en_q;

   assign ack_clr = irq_ack ? taken_q : '0;

   irqv_pending #(.N(NUM_SRC)) u_pending (
      .clk   (clk),
      .rst_n (rst_n),
      .lines (irq_lines),
      .clr   (ack_clr),
      .pend  (pend)
   );

   assign live = pend & en_q;

   irqv_prio #(.N(NUM_SRC), .IW(IDX_W), .IMPL(PRIO_IMPL)) u_prio (
      .req   (live),
      .valid (win_valid),
      .idx   (win_idx)
   );

   assign take = gie_q & win_valid;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_q   <= 1'b0;
         slot_q  <= '0;
         gie_q   <= 1'b0;
         en_q    <= '0;
         taken_q <= '0;
      end else begin
         req_q <= 1'b0;
         if (rst_req) begin
            req_q  <= 1'b1;
            slot_q <= '0;
            gie_q  <= 1'b0;
            en_q   <= '0;
         end else begin
            if (en_wr) en_q <= en_wdata;
            if (take) begin
               req_q   <= 1'b1;
               slot_q  <= win_idx + IDX_W'(1);
               taken_q <= NUM_SRC'(1) << win_idx;
               gie_q   <= 1'b0;
            end else if (gie_wr) begin
               gie_q <= gie_wdata;
            end else if (reti) begin
               gie_q <= 1'b1;
            end
         end
      end
   end

   irqv_vecgen #(.IW(IDX_W), .AW(ADDR_W), .BASE(VEC_BASE), .STRIDE(VEC_STRIDE)) u_vecgen (
      .slot (slot_q),
      .addr (irq_vec)
   );

   assign irq_req = req_q;
   assign gie     = gie_q;
   assign en      = en_q;

endmodule

module irqv_checker #(
   parameter int NUM_SRC    = 17,
   parameter int ADDR_W     = 13,
   parameter int VEC_BASE   = 0,
   parameter int VEC_STRIDE = 2
) (
   input logic               clk,
   input logic               rst_n,
   input logic               rst_req,
   input logic               gie_wr,
   input logic               reti,
   input logic               gie,
   input logic [NUM_SRC-1:0] en,
   input logic               irq_req,
   input logic [ADDR_W-1:0]  irq_vec
);

   logic src_strobe;
   assign src_strobe = irq_req && (irq_vec != ADDR_W'(VEC_BASE));

   p_reset_take_r1: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req |=> (irq_req && irq_vec == ADDR_W'(VEC_BASE) && en == '0 && !gie));

   p_masked_global_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!gie && !rst_req) |=> !src_strobe);

   p_vec_aligned_r5: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |-> ((int'(irq_vec) - VEC_BASE) % VEC_STRIDE == 0));

   p_gie_low_on_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |-> !gie);

   p_single_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
      src_strobe |=> !src_strobe);

   p_reti_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (reti && !gie && !gie_wr && !rst_req) |=> gie);

endmodule

bind irq_vector_arbiter irqv_checker #(
   .NUM_SRC    (NUM_SRC),
   .ADDR_W     (ADDR_W),
   .VEC_BASE   (VEC_BASE),
   .VEC_STRIDE (VEC_STRIDE)
) u_irqv_checker (
   .clk     (clk),
   .rst_n   (rst_n),
   .rst_req (rst_req),
   .gie_wr  (gie_wr),
   .reti    (reti),
   .gie     (gie),
   .en      (en),
   .irq_req (irq_req),
   .irq_vec (irq_vec)
);

// File: tb/test_irq_vector_arbiter.sv
module test_irq_vector_arbiter;

   localparam int N  = 17;
   localparam int AW = 13;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          rst_req = 1'b0;
   logic [N-1:0]  irq_lines = '0;
   logic          en_wr = 1'b0;
   logic [N-1:0]  en_wdata = '0;
   logic [N-1:0]  en;
   logic          gie_wr = 1'b0;
   logic          gie_wdata = 1'b0;
   logic          gie;
   logic          reti = 1'b0;
   logic          irq_ack = 1'b0;
   logic          irq_req;
   logic [AW-1:0] irq_vec;

   int nchk = 0;
   int nfail = 0;

   always #2 clk = ~clk;

   irq_vector_arbiter i_irq_vector_arbiter (
      .clk(clk), .rst_n(rst_n), .rst_req(rst_req), .irq_lines(irq_lines),
      .en_wr(en_wr), .en_wdata(en_wdata), .en(en),
      .gie_wr(gie_wr), .gie_wdata(gie_wdata), .gie(gie),
      .reti(reti), .irq_ack(irq_ack), .irq_req(irq_req), .irq_vec(irq_vec)
   );

   task automatic chk(input string tag, input int act, input int exp);
      nchk++;
      if (act != exp) begin
         nfail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic set_en(input logic [N-1:0] m);
      @(negedge clk); en_wr = 1'b1; en_wdata = m;
      @(negedge clk); en_wr = 1'b0;
   endtask

   task automatic set_gie(input logic v);
      @(negedge clk); gie_wr = 1'b1; gie_wdata = v;
      @(negedge clk); gie_wr = 1'b0;
   endtask

   task automatic pulse_lines(input logic [N-1:0] m);
      @(negedge clk); irq_lines = m;
      @(negedge clk); irq_lines = '0;
   endtask

   task automatic wait_strobe(input int maxc, output bit seen, output int vec, output int cyc);
      seen = 1'b0; vec = -1; cyc = 0;
      for (int c = 1; c <= maxc; c++) begin
         @(posedge clk); #1;
         if (irq_req) begin
            seen = 1'b1; vec = int'(irq_vec); cyc = c;
            return;
         end
      end
   endtask

   task automatic serve();
      @(negedge clk); irq_ack = 1'b1;
      @(negedge clk); irq_ack = 1'b0; reti = 1'b1;
      @(negedge clk); reti = 1'b0;
   endtask

   task automatic t_reset_state();
      chk("R9 reset gie", int'(gie), 0);
      chk("R9 reset en", int'(en), 0);
      chk("R6 reset strobe", int'(irq_req), 0);
   endtask

   task automatic t_enable_rw();
      set_en(17'h0A5A5);
      chk("R9 en readback", int'(en), 'h0A5A5);
      set_gie(1'b1);
      chk("R9 gie readback", int'(gie), 1);
      set_gie(1'b0);
      chk("R9 gie cleared", int'(gie), 0);
   endtask

   task automatic t_single();
      bit s; int v; int c;
      set_en('1);
      set_gie(1'b1);
      pulse_lines(N'(1) << 3);
      wait_strobe(6, s, v, c);
      chk("R3 strobe seen", int'(s), 1);
      chk("R3 latency", c, 1);
      chk("R5 vector line3", v, 8);
      chk("R6 gie low with strobe", int'(gie), 0);
      @(posedge clk); #1;
      chk("R6 strobe one cycle", int'(irq_req), 0);
      serve();
      chk("R7 reti sets gie", int'(gie), 1);
      wait_strobe(6, s, v, c);
      chk("R8 acked source not retaken", int'(s), 0);
   endtask

   task automatic t_masked();
      bit s; int v; int c;
      set_en('1 & ~(N'(1) << 5));
      pulse_lines(N'(1) << 5);
      wait_strobe(8, s, v, c);
      chk("R2 masked not taken", int'(s), 0);
      set_en('1);
      wait_strobe(4, s, v, c);
      chk("R2 taken after unmask", int'(s), 1);
      chk("R5 vector line5", v, 12);
      serve();
   endtask

   task automatic t_global_off();
      bit s; int v; int c;
      set_gie(1'b0);
      pulse_lines(N'(1));
      wait_strobe(8, s, v, c);
      chk("R3 gie off blocks", int'(s), 0);
      set_gie(1'b1);
      wait_strobe(4, s, v, c);
      chk("R5 vector line0", v, 2);
      serve();
   endtask

   task automatic t_priority();
      bit s; int v; int c;
      pulse_lines((N'(1) << 16) | (N'(1) << 7) | (N'(1) << 2));
      wait_strobe(6, s, v, c);
      chk("R4 first winner", v, 6);
      wait_strobe(4, s, v, c);
      chk("R6 no take while gie low", int'(s), 0);
      serve();
      wait_strobe(4, s, v, c);
      chk("R8 second winner", v, 16);
      serve();
      wait_strobe(4, s, v, c);
      chk("R8 third winner", v, 34);
      serve();
   endtask

   task automatic t_gie_conflict();
      set_gie(1'b0);
      @(negedge clk); gie_wr = 1'b1; gie_wdata = 1'b0; reti = 1'b1;
      @(negedge clk); gie_wr = 1'b0; reti = 1'b0;
      chk("R7 write beats reti", int'(gie), 0);
      @(negedge clk); reti = 1'b1;
      @(negedge clk); reti = 1'b0;
      chk("R7 reti alone", int'(gie), 1);
   endtask

   task automatic t_reset_request();
      set_en('1);
      set_gie(1'b1);
      @(negedge clk); rst_req = 1'b1;
      @(negedge clk); rst_req = 1'b0;
      chk("R1 reset strobe", int'(irq_req), 1);
      chk("R1 reset vector", int'(irq_vec), 0);
      chk("R1 gie cleared", int'(gie), 0);
      chk("R1 enables cleared", int'(en), 0);
      @(posedge clk); #1;
      chk("R1 strobe ends", int'(irq_req), 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset_state();
      t_enable_rw();
      t_single();
      t_masked();
      t_global_off();
      t_priority();
      t_gie_conflict();
      t_reset_request();
      repeat (2) @(negedge clk);
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end

endmodule